// File: doc/BRIEF.md
# Byte-Staged Register PWM Generator

This block produces a single pulse-width-modulated output whose period and high time are counted in ticks of an external strobe (nominally one tick every 125 ns, from an 8 MHz time base). A host programs it over a narrow write-only bus of 8-bit data with 8-bit addresses. The two 16-bit settings, period and high time, are each split into an upper and a lower byte; writing the upper byte only parks it in a holding register, and the full 16-bit value is committed when the lower byte arrives, so a half-written value never reaches the counter.

Committed settings are taken into the active compare registers only at the end of a period, so every emitted period is whole. A one-bit enable starts and stops the output; stopping lets the current period finish and then holds the output low. A 16-bit auto-off countdown, decremented once every 2^PRE_W ticks while the output is enabled, clears the enable when it runs out; the value 0xFFFF switches the countdown off. The output is active high during the first part of each period only; there is no readback.

The period engine is a three-state machine. IDLE holds the counter at zero with the output low; the transition IDLE->RUN (start) happens when the enable is set and loads the active settings. RUN counts ticks; at the period end with the enable still set it reloads and stays in RUN (wrap). If the enable drops in RUN it goes RUN->LAST (drain), or directly RUN->IDLE (stop) when the drop meets a period end; LAST->IDLE (stop) happens at the end of the period being finished.

Top module: `staged_pwm`

## Requirements
- R1: After reset every register is zero, the output is low and the generator is disabled; the output stays low until enabled.
- R2: With period P >= 1 and high time D, the counter advances only on tick strobes and the output is high for the first min(D, P) ticks of every P-tick period; a period of 0 behaves as 1.
- R3: When the committed high time is greater than or equal to the committed period, the output is high for the whole period.
- R4: A committed high time of 0 keeps the output low.
- R5: Writes to the upper-byte addresses 0xA5 (period), 0xA7 (high time) and 0xA1 (auto-off) only stage the byte; the 16-bit value {upper, lower} is committed by the write to the matching lower-byte address 0xA4, 0xA6 or 0xA2.
- R6: A newly committed period or high time takes effect only at the end of the period in progress.
- R7: Writing address 0xA3 with data bit 0 set enables the output; writing it with bit 0 clear stops it at the end of the current period, after which the output is low and the counter holds at zero.
- R8: With an auto-off value N other than 0xFFFF and the output enabled, the enable clears after N decrement steps of 2^PRE_W ticks each (a value of 0 expires at the first step); each write to 0xA2 reloads the countdown.
- R9: An auto-off value of 0xFFFF disables the countdown, so the output runs indefinitely.
- R10: Writes to any address outside 0xA1 to 0xA7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base strobe, one clock wide per tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | CNT_W/2 | Register write data byte |
| pwm_out | output | 1 | PWM output, active high |

## Verification
The hardest situations to reach are those that depend on where inside a period a host write lands: a commit that must wait for the wrap, and a stop that must let the running period finish. The stimulus waits for a rising edge of the output, which marks count zero, and then issues the write in parallel with a process that measures the length of that high pulse. The auto-off countdown is brought within reach by setting the prescaler width to one bit, so that the disabled value 0xFFFF can be exercised for longer than a full countdown would last.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

    localparam int ADDR_W = 8;

    // Upper/lower byte addresses for the three staged pairs.
    // Index 0: period, index 1: high time, index 2: auto-off.
    localparam logic [2:0][ADDR_W-1:0] PAIR_HI_ADDR = {8'hA1, 8'hA7, 8'hA5};
    localparam logic [2:0][ADDR_W-1:0] PAIR_LO_ADDR = {8'hA2, 8'hA6, 8'hA4};
    localparam logic [ADDR_W-1:0]      ADDR_ENABLE  = 8'hA3;

    localparam int PAIR_PERIOD = 0;
    localparam int PAIR_HIGH   = 1;
    localparam int PAIR_AUTO   = 2;
    localparam int NUM_PAIRS   = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_LAST = 2'd2
    } run_state_t;

endpackage

// File: rtl/spwm_regs.sv
module spwm_regs
    import spwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              expire,
    output logic [CNT_W-1:0]  per_cfg,
    output logic [CNT_W-1:0]  high_cfg,
    output logic [CNT_W-1:0]  auto_cfg,
    output logic              auto_ld,
    output logic              en_q
);

    logic [NUM_PAIRS-1:0][CNT_W-1:0] pair_val;
    logic [NUM_PAIRS-1:0]            pair_commit;

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        logic [DATA_W-1:0] hi_stage;
        logic [CNT_W-1:0]  val_q;
        logic              hit_hi;
        logic              hit_lo;

        assign hit_hi = wr_en && (wr_addr == PAIR_HI_ADDR[g]);
        assign hit_lo = wr_en && (wr_addr == PAIR_LO_ADDR[g]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_stage <= '0;
                val_q    <= '0;
            end else if (hit_hi) begin
                hi_stage <= wr_data;
            end else if (hit_lo) begin
                val_q    <= {hi_stage, wr_data};
            end
        end

        assign pair_val[g]    = val_q;
        assign pair_commit[g] = hit_lo;
    end

    assign per_cfg  = pair_val[PAIR_PERIOD];
    assign high_cfg = pair_val[PAIR_HIGH];
    assign auto_cfg = pair_val[PAIR_AUTO];

    // Reload pulse for the countdown, one cycle after the commit so the
    // committed value is already visible.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_ld <= 1'b0;
        end else begin
            auto_ld <= pair_commit[PAIR_AUTO];
        end
    end

    // Enable bit: a host write wins over an expiring countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (wr_en && (wr_addr == ADDR_ENABLE)) begin
            en_q <= wr_data[0];
        end else if (expire) begin
            en_q <= 1'b0;
        end
    end

endmodule

// File: rtl/spwm_autooff.sv
module spwm_autooff #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic [CNT_W-1:0] auto_cfg,
    input  logic             auto_ld,
    output logic             expire,
    output logic [CNT_W-1:0] remain
);

    localparam logic [CNT_W-1:0] OFF_CODE = '1;
    localparam logic [PRE_W-1:0] PRE_LAST = '1;

    logic [PRE_W-1:0] pre_cnt;
    logic             timer_off;
    logic             step;

    assign timer_off = (auto_cfg == OFF_CODE);
    assign step      = en && !timer_off && tick && (pre_cnt == PRE_LAST);
    assign expire    = step && (remain <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            remain  <= '0;
        end else if (auto_ld) begin
            pre_cnt <= '0;
            remain  <= auto_cfg;
        end else if (!en || timer_off) begin
            pre_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= pre_cnt + 1'b1;
            if (step && (remain != '0)) begin
                remain <= remain - 1'b1;
            end
        end
    end

endmodule

// File: rtl/spwm_core.sv
module spwm_core
    import spwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic [CNT_W-1:0] per_cfg,
    input  logic [CNT_W-1:0] high_cfg,
    output logic             pwm_out,
    output run_state_t       state,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] act_per,
    output logic [CNT_W-1:0] act_high,
    output logic             load_now
);

    run_state_t nxt;
    logic       wrap;

    assign wrap = tick && (({1'b0, cnt} + 1'b1) >= {1'b0, act_per});

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (en) nxt = ST_RUN;
            ST_RUN: begin
                if (!en) nxt = wrap ? ST_IDLE : ST_LAST;
            end
            ST_LAST: if (wrap) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    assign load_now = en && ((state == ST_IDLE) || ((state == ST_RUN) && wrap));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Counter and active compare registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            act_per  <= '0;
            act_high <= '0;
        end else begin
            if (load_now) begin
                act_per  <= per_cfg;
                act_high <= high_cfg;
            end
            if (state == ST_IDLE) begin
                cnt <= '0;
            end else if (tick) begin
                cnt <= wrap ? '0 : cnt + 1'b1;
            end
        end
    end

    // Output
    always_comb begin
        pwm_out = (state != ST_IDLE) && (cnt < act_high);
    end

endmodule

// File: rtl/staged_pwm.sv
module staged_pwm
    import spwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 16,
    localparam int DATA_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out
);

    logic [CNT_W-1:0] per_cfg;
    logic [CNT_W-1:0] high_cfg;
    logic [CNT_W-1:0] auto_cfg;
    logic             auto_ld;
    logic             en_q;
    logic             expire;
    logic [CNT_W-1:0] auto_remain;
    run_state_t       core_st;
    logic [CNT_W-1:0] core_cnt;
    logic [CNT_W-1:0] act_per;
    logic [CNT_W-1:0] act_high;
    logic             load_now;

    spwm_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .expire   (expire),
        .per_cfg  (per_cfg),
        .high_cfg (high_cfg),
        .auto_cfg (auto_cfg),
        .auto_ld  (auto_ld),
        .en_q     (en_q)
    );

    spwm_autooff #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_auto (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .en       (en_q),
        .auto_cfg (auto_cfg),
        .auto_ld  (auto_ld),
        .expire   (expire),
        .remain   (auto_remain)
    );

    spwm_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .en       (en_q),
        .per_cfg  (per_cfg),
        .high_cfg (high_cfg),
        .pwm_out  (pwm_out),
        .state    (core_st),
        .cnt      (core_cnt),
        .act_per  (act_per),
        .act_high (act_high),
        .load_now (load_now)
    );

endmodule

// File: rtl/staged_pwm_chk.sv
module staged_pwm_chk
    import spwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              pwm_out,
    input run_state_t        st,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  act_per,
    input logic [CNT_W-1:0]  act_high,
    input logic              load_now,
    input logic              en,
    input logic              expire,
    input logic [CNT_W-1:0]  auto_cfg,
    input logic              auto_ld,
    input logic [CNT_W-1:0]  remain,
    input logic [CNT_W-1:0]  per_cfg
);

    localparam logic [CNT_W-1:0] OFF_CODE = '1;

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st != ST_IDLE) && (act_per != '0)) |-> (cnt < act_per));

    assert_full_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((st != ST_IDLE) && (act_per != '0) && (act_high >= act_per)) |-> pwm_out);

    assert_zero_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_high == '0) |-> !pwm_out);

    assert_stage_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == PAIR_HI_ADDR[PAIR_PERIOD])) |=> $stable(per_cfg));

    assert_hold_mid_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st != ST_IDLE) && !load_now) |=> ($stable(act_per) && $stable(act_high)));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!pwm_out && (cnt == '0)));

    assert_expire_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !(wr_en && (wr_addr == ADDR_ENABLE))) |=> !en);

    assert_timer_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((auto_cfg == OFF_CODE) && !auto_ld) |=> $stable(remain));

endmodule

bind staged_pwm staged_pwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .pwm_out  (pwm_out),
    .st       (core_st),
    .cnt      (core_cnt),
    .act_per  (act_per),
    .act_high (act_high),
    .load_now (load_now),
    .en       (en_q),
    .expire   (expire),
    .auto_cfg (auto_cfg),
    .auto_ld  (auto_ld),
    .remain   (auto_remain),
    .per_cfg  (per_cfg)
);

// File: tb/tb_staged_pwm.sv
module tb_staged_pwm;

    localparam int CNT_W = 16;
    localparam int PRE_W = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       pwm_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int tick_div = 1;
    int tick_ctr = 0;

    staged_pwm #(.CNT_W(CNT_W), .PRE_W(PRE_W)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    always #10 clk = ~clk;

    // Tick strobe: every cycle, or one cycle in tick_div.
    always @(negedge clk) begin
        tick_ctr <= tick_ctr + 1;
        tick     <= (tick_div <= 1) ? 1'b1 : ((tick_ctr % tick_div) == 0);
    end

    function automatic int exp_high(input int per, input int high);
        int p;
        p = (per < 1) ? 1 : per;
        return (high >= p) ? p : high;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 8'h00; wr_data = 8'h00;
    endtask

    task automatic set16(input logic [7:0] hi_a, input logic [7:0] lo_a, input int v);
        wr(hi_a, 8'((v >> 8) & 255));
        wr(lo_a, 8'(v & 255));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int n, output int highs);
        highs = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_out) highs++;
        end
    endtask

    task automatic wait_rise();
        logic prev;
        int guard;
        prev = 1'b1;
        guard = 0;
        while (guard < 2000) begin
            @(negedge clk);
            if (pwm_out && !prev) break;
            prev = pwm_out;
            guard++;
        end
    endtask

    task automatic high_run(output int run);
        run = 1;
        while (run < 400) begin
            @(negedge clk);
            if (!pwm_out) break;
            run++;
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int h;
        int run;
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 reset out", int'(pwm_out), 0);
        measure(30, h);
        check("R1 quiet after reset", h, 0);

        // Configure without enabling: still low (R7)
        set16(8'hA1, 8'hA2, 16'hFFFF);
        set16(8'hA5, 8'hA4, 10);
        set16(8'hA7, 8'hA6, 4);
        measure(40, h);
        check("R7 disabled stays low", h, 0);

        // R2: basic waveform
        wr(8'hA3, 8'h01);
        idle(30);
        measure(50, h);
        check("R2 period 10 high 4", h, 20);

        // R5: upper byte alone only stages
        wr(8'hA7, 8'h01);
        idle(30);
        measure(50, h);
        check("R5 upper byte staged only", h, 20);
        wr(8'hA6, 8'h04);   // commits 0x0104 = 260 > 10
        idle(30);
        measure(50, h);
        check("R3 high time above period", h, 50);
        set16(8'hA7, 8'hA6, 10);
        idle(30);
        measure(50, h);
        check("R3 high time equals period", h, 50);

        // R4: zero high time
        set16(8'hA7, 8'hA6, 0);
        idle(30);
        measure(50, h);
        check("R4 zero high time", h, 0);

        // R10: unmapped addresses ignored
        set16(8'hA7, 8'hA6, 3);
        idle(30);
        wr(8'hA0, 8'hFF);
        wr(8'hA8, 8'h00);
        wr(8'h23, 8'h00);
        idle(30);
        measure(50, h);
        check("R10 unmapped writes ignored", h, 15);

        // R2: tick gating, one tick in four
        tick_div = 4;
        idle(200);
        measure(80, h);
        check("R2 gated ticks", h, 24);
        tick_div = 1;
        idle(60);

        // R2/R3/R4: constrained random settings
        for (int i = 0; i < 40; i++) begin
            int p;
            int d;
            p = 1 + int'($urandom % 40);
            d = int'($urandom % 48);
            set16(8'hA5, 8'hA4, p);
            set16(8'hA7, 8'hA6, d);
            idle(100);
            measure(3 * p, h);
            check($sformatf("R2 random p=%0d d=%0d", p, d), h, 3 * exp_high(p, d));
        end

        // R6: commit mid-period waits for the wrap
        set16(8'hA5, 8'hA4, 40);
        set16(8'hA7, 8'hA6, 20);
        idle(100);
        wait_rise();
        fork
            begin wr(8'hA7, 8'h00); wr(8'hA6, 8'd40); end
            high_run(run);
        join
        check("R6 old high time kept to wrap", run, 20);
        idle(90);
        measure(80, h);
        check("R6 new high time after wrap", h, 80);

        // R7: stop finishes the current period
        set16(8'hA5, 8'hA4, 20);
        set16(8'hA7, 8'hA6, 10);
        idle(80);
        wait_rise();
        fork
            wr(8'hA3, 8'h00);
            high_run(run);
        join
        check("R7 current period finished", run, 10);
        measure(60, h);
        check("R7 low after stop", h, 0);

        // R8: auto-off countdown, 2 ticks per step with PRE_W = 1
        set16(8'hA5, 8'hA4, 4);
        set16(8'hA7, 8'hA6, 8);
        set16(8'hA1, 8'hA2, 5);
        wr(8'hA3, 8'h01);
        idle(4);
        check("R8 running before expiry", int'(pwm_out), 1);
        idle(30);
        measure(30, h);
        check("R8 expired after 5 steps", h, 0);

        // R8: lower-byte write reloads the countdown
        set16(8'hA1, 8'hA2, 20);
        wr(8'hA3, 8'h01);
        idle(30);
        wr(8'hA2, 8'd20);
        idle(25);
        check("R8 reload keeps output alive", int'(pwm_out), 1);
        idle(40);
        measure(20, h);
        check("R8 expired after reload", h, 0);

        // R9: 0xFFFF disables auto-off beyond the longest countdown
        set16(8'hA1, 8'hA2, 16'hFFFF);
        wr(8'hA3, 8'h01);
        idle(132000);
        measure(100, h);
        check("R9 auto-off disabled", h, 100);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule